// File: doc/BRIEF.md
# Fine-Tuned PTP Time Counter

This block keeps the local time base of a network timestamping unit. It runs on a 125 MHz clock. On each `tick_i` pulse it moves the time forward by a fixed 8 ns step. A signed fractional rate trim adjusts the average rate in very fine steps. A 32-bit fractional accumulator adds the trim magnitude on every advance. When the accumulator carries out, that one step becomes 9 ns, or 7 ns when the trim sign asks the clock to slow down.

Software reaches the counter through a small 32-bit register port with read and write strobes. The register addresses are:

| Address | Register |
|---|---|
| 0 | Fractional residue |
| 1 | Time low word |
| 2 | Time high word |
| 3 | Rate trim |
| 4 | Control |

Reading the residue register freezes a copy of the full time, so the low and high words read afterwards belong to the same instant. Writing the low word and then the high word loads a new time in one step. A control bit can halt the timer.

A build parameter selects one of two time formats:
- a 40-bit binary nanosecond count;
- a seconds word paired with a nanoseconds word that rolls over at 10^9.

The current time is also presented live on two output words, for use by the stamping logic next to the counter.

Top module: `tsu_time_counter`

## Requirements
- R1: After reset the control register reads 0x8000_0000 (timer halted), the rate trim and the residue read 0, and the live time is 0.
- R2: While control bit 31 is 1, `tick_i` pulses change neither the time nor the residue. Writing a value with bit 31 clear lets the timer run from the next cycle.
- R3: With a trim magnitude of 0, each cycle with `tick_i` high and the timer running adds exactly 8 ns. A cycle with `tick_i` low leaves the time unchanged.
- R4: The rate trim word at address 3 holds a sign in bit 31 (1 = slow) and a magnitude in bits 30:0. Each advance adds the magnitude to the 32-bit residue. A carry out of that add makes the step 9 ns when the sign is 0 and 7 ns when the sign is 1.
- R5: In binary mode (SECNS_MODE = 0) the time is a 40-bit nanosecond count. Bits 31:0 appear in the low word and bits 39:32 appear in bits 7:0 of the high word. Bits 31:8 of the high word read as 0. The count wraps modulo 2^40.
- R6: In seconds mode (SECNS_MODE = 1) the high word holds seconds and the low word holds nanoseconds. When nanoseconds plus the step reaches 10^9 or more, 10^9 is subtracted and seconds increases by 1. For loaded nanosecond values below 10^9, the nanoseconds stay below 10^9.
- R7: A read of address 0 returns the residue and copies the current time into a snapshot. Reads of address 1 and address 2 return the snapshot low and high words, even after the live time has moved on.
- R8: A write to address 1 changes no time by itself; the value is held. A write to address 2 loads the time from the written high word and the held low word, and clears the residue, at the end of that cycle. Writes to address 0 are ignored.
- R9: When a high-word write and a tick fall in the same cycle, the load wins and the loaded time is not advanced.
- R10: Read data appears on `reg_rdata_o` in the cycle after the read strobe. The rate trim reads back as written. The control register reads back only bit 31. Unmapped addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Advance strobe, one per nominal step |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one cycle after the read strobe |
| time_hi_o | output | 32 | Live high time word (seconds, or count bits 39:32) |
| time_lo_o | output | 32 | Live low time word (nanoseconds, or count bits 31:0) |

## Verification
The hardest conditions to reach from the ports are the step corners: a 1 ns trim correction landing on a 2^40 wrap, or on a nanosecond rollover at 10^9. Hitting these at random would take far longer than any run allows. The stimulus therefore loads times a few nanoseconds short of each boundary and sets the trim to quarter and minus-quarter magnitudes, so carries fall on known ticks. Seeded random traffic then mixes loads, trim changes, halts and snapshot reads against a bench model of both formats. This includes loads whose nanoseconds exceed 10^9.

// File: rtl/tsu_pkg.sv
`timescale 1ns/1ps
package tsu_pkg;
   localparam int TSU_ADDR_W = 3;
   localparam int TSU_HALT_BIT = 31;

   typedef enum logic [TSU_ADDR_W-1:0] {
      REG_FRAC = 3'd0,
      REG_TLO  = 3'd1,
      REG_THI  = 3'd2,
      REG_RATE = 3'd3,
      REG_CTRL = 3'd4
   } tsu_reg_e;
endpackage

// File: rtl/tsu_rate_trim.sv
`timescale 1ns/1ps
module tsu_rate_trim #(
   parameter int FRAC_W  = 32,
   parameter int STEP_NS = 8,
   parameter int STEP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              clear_i,
   input  logic [FRAC_W-1:0] rate_i,
   output logic [STEP_W-1:0] step_o,
   output logic [FRAC_W-1:0] residue_o
);
   localparam logic [STEP_W-1:0] STEP_NOM  = STEP_W'(STEP_NS);
   localparam logic [STEP_W-1:0] STEP_FAST = STEP_W'(STEP_NS + 1);
   localparam logic [STEP_W-1:0] STEP_SLOW = STEP_W'(STEP_NS - 1);

   if (FRAC_W < 2) begin : g_bad_frac
      $error("tsu_rate_trim: FRAC_W must be at least 2");
   end
   if (STEP_NS < 2 || (STEP_NS + 1) >= (1 << STEP_W)) begin : g_bad_step
      $error("tsu_rate_trim: STEP_NS does not fit STEP_W");
   end

   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   acc_sum;
   logic              slow_dir;

   assign slow_dir = rate_i[FRAC_W-1];
   assign acc_sum  = {1'b0, acc_q} + {2'b00, rate_i[FRAC_W-2:0]};

   always_comb begin
      if (!acc_sum[FRAC_W])
         step_o = STEP_NOM;
      else if (slow_dir)
         step_o = STEP_SLOW;
      else
         step_o = STEP_FAST;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clear_i)
         acc_q <= '0;
      else if (adv_i)
         acc_q <= acc_sum[FRAC_W-1:0];
   end

   assign residue_o = acc_q;

   // R4
   slow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o == STEP_SLOW) |-> slow_dir);

   // R8
   clear_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (residue_o == '0));

   // R2
   hold_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !clear_i) |=> $stable(residue_o));
endmodule

// File: rtl/tsu_time_core.sv
`timescale 1ns/1ps
module tsu_time_core #(
   parameter bit SECNS_MODE = 1'b0,
   parameter int WORD_W     = 32,
   parameter int BIN_W      = 40,
   parameter int STEP_W     = 4,
   parameter int NS_PER_SEC = 1000000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic [STEP_W-1:0] step_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_hi_i,
   input  logic [WORD_W-1:0] load_lo_i,
   output logic [WORD_W-1:0] hi_o,
   output logic [WORD_W-1:0] lo_o
);
   if (SECNS_MODE) begin : g_secns
      localparam logic [WORD_W:0]   NS_LIM = (WORD_W+1)'(NS_PER_SEC);
      localparam logic [WORD_W-1:0] NS_TOP = WORD_W'(NS_PER_SEC);

      logic [WORD_W-1:0] sec_q;
      logic [WORD_W-1:0] ns_q;
      logic [WORD_W:0]   ns_sum;
      logic [WORD_W:0]   ns_wrap;

      assign ns_sum  = {1'b0, ns_q} + (WORD_W+1)'(step_i);
      assign ns_wrap = ns_sum - NS_LIM;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
         end else if (load_i) begin
            sec_q <= load_hi_i;
            ns_q  <= load_lo_i;
         end else if (adv_i) begin
            if (ns_sum >= NS_LIM) begin
               ns_q  <= ns_wrap[WORD_W-1:0];
               sec_q <= sec_q + 1'b1;
            end else begin
               ns_q  <= ns_sum[WORD_W-1:0];
            end
         end
      end

      assign hi_o = sec_q;
      assign lo_o = ns_q;

      // R6
      ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (adv_i && !load_i && ns_q < NS_TOP) |=> (ns_q < NS_TOP));

      // R6
      sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (adv_i && !load_i && ns_q < NS_TOP && ns_sum >= NS_LIM)
         |=> (sec_q == $past(sec_q) + 1'b1));

      // R9
      sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load_i |=> (sec_q == $past(load_hi_i) && ns_q == $past(load_lo_i)));

      // R2
      sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!adv_i && !load_i) |=> ($stable(sec_q) && $stable(ns_q)));
   end else begin : g_binary
      localparam int HI_USED = BIN_W - WORD_W;

      if (BIN_W <= WORD_W || BIN_W >= 2 * WORD_W) begin : g_bad_width
         $error("tsu_time_core: BIN_W must lie between WORD_W and 2*WORD_W");
      end

      logic [BIN_W-1:0] cnt_q;
      logic             unused_hi_bits;

      assign unused_hi_bits = &{1'b0, load_hi_i[WORD_W-1:HI_USED]};

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (load_i)
            cnt_q <= {load_hi_i[HI_USED-1:0], load_lo_i};
         else if (adv_i)
            cnt_q <= cnt_q + BIN_W'(step_i);
      end

      assign hi_o = {{(WORD_W-HI_USED){1'b0}}, cnt_q[BIN_W-1:WORD_W]};
      assign lo_o = cnt_q[WORD_W-1:0];

      // R9
      load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load_i |=> (cnt_q == $past({load_hi_i[HI_USED-1:0], load_lo_i})));

      // R3
      step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (adv_i && !load_i) |=> ((cnt_q - $past(cnt_q)) == BIN_W'($past(step_i))));

      // R2
      halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!adv_i && !load_i) |=> $stable(cnt_q));
   end
endmodule

// File: rtl/tsu_reg_port.sv
`timescale 1ns/1ps
module tsu_reg_port
   import tsu_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int FRAC_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  logic                  rd_i,
   input  logic [TSU_ADDR_W-1:0] addr_i,
   input  logic [WORD_W-1:0]     wdata_i,
   input  logic [WORD_W-1:0]     live_hi_i,
   input  logic [WORD_W-1:0]     live_lo_i,
   input  logic [FRAC_W-1:0]     residue_i,
   output logic [WORD_W-1:0]     rdata_o,
   output logic [FRAC_W-1:0]     rate_o,
   output logic                  run_o,
   output logic                  load_o,
   output logic [WORD_W-1:0]     load_hi_o,
   output logic [WORD_W-1:0]     load_lo_o
);
   if (FRAC_W != WORD_W || WORD_W <= TSU_HALT_BIT) begin : g_bad_word
      $error("tsu_reg_port: FRAC_W must equal WORD_W and hold the halt bit");
   end

   logic [FRAC_W-1:0] rate_q;
   logic              halt_q;
   logic [WORD_W-1:0] pend_lo_q;
   logic [WORD_W-1:0] snap_hi_q;
   logic [WORD_W-1:0] snap_lo_q;
   logic [WORD_W-1:0] rdata_q;
   logic              snap_take;

   assign snap_take = rd_i && (addr_i == REG_FRAC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q    <= '0;
         halt_q    <= 1'b1;
         pend_lo_q <= '0;
      end else if (wr_i) begin
         case (addr_i)
            REG_TLO:  pend_lo_q <= wdata_i;
            REG_RATE: rate_q    <= wdata_i;
            REG_CTRL: halt_q    <= wdata_i[TSU_HALT_BIT];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_hi_q <= '0;
         snap_lo_q <= '0;
      end else if (snap_take) begin
         snap_hi_q <= live_hi_i;
         snap_lo_q <= live_lo_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_i) begin
         case (addr_i)
            REG_FRAC: rdata_q <= residue_i;
            REG_TLO:  rdata_q <= snap_lo_q;
            REG_THI:  rdata_q <= snap_hi_q;
            REG_RATE: rdata_q <= rate_q;
            REG_CTRL: rdata_q <= {halt_q, {(WORD_W-1){1'b0}}};
            default:  rdata_q <= '0;
         endcase
      end
   end

   assign rdata_o   = rdata_q;
   assign rate_o    = rate_q;
   assign run_o     = !halt_q;
   assign load_o    = wr_i && (addr_i == REG_THI);
   assign load_hi_o = wdata_i;
   assign load_lo_o = pend_lo_q;

   // R7
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_take |=> ($stable(snap_hi_q) && $stable(snap_lo_q)));

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));

   // R8
   lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == REG_TLO) |=> (load_lo_o == $past(wdata_i)));
endmodule

// File: rtl/tsu_time_counter.sv
`timescale 1ns/1ps
module tsu_time_counter
   import tsu_pkg::*;
#(
   parameter bit SECNS_MODE = 1'b0,
   parameter int WORD_W     = 32,
   parameter int BIN_W      = 40,
   parameter int FRAC_W     = 32,
   parameter int STEP_NS    = 8,
   parameter int NS_PER_SEC = 1000000000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_i,
   input  logic                  reg_wr_i,
   input  logic                  reg_rd_i,
   input  logic [TSU_ADDR_W-1:0] reg_addr_i,
   input  logic [WORD_W-1:0]     reg_wdata_i,
   output logic [WORD_W-1:0]     reg_rdata_o,
   output logic [WORD_W-1:0]     time_hi_o,
   output logic [WORD_W-1:0]     time_lo_o
);
   localparam int STEP_W = $clog2(STEP_NS + 2);

   if (NS_PER_SEC <= STEP_NS + 1) begin : g_bad_sec
      $error("tsu_time_counter: NS_PER_SEC too small for the step");
   end

   logic              run;
   logic              load;
   logic              adv;
   logic [FRAC_W-1:0] rate;
   logic [FRAC_W-1:0] residue;
   logic [STEP_W-1:0] step;
   logic [WORD_W-1:0] load_hi;
   logic [WORD_W-1:0] load_lo;

   assign adv = tick_i && run && !load;

   tsu_reg_port #(
      .WORD_W (WORD_W),
      .FRAC_W (FRAC_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_wr_i),
      .rd_i      (reg_rd_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .live_hi_i (time_hi_o),
      .live_lo_i (time_lo_o),
      .residue_i (residue),
      .rdata_o   (reg_rdata_o),
      .rate_o    (rate),
      .run_o     (run),
      .load_o    (load),
      .load_hi_o (load_hi),
      .load_lo_o (load_lo)
   );

   tsu_rate_trim #(
      .FRAC_W  (FRAC_W),
      .STEP_NS (STEP_NS),
      .STEP_W  (STEP_W)
   ) u_trim (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (adv),
      .clear_i   (load),
      .rate_i    (rate),
      .step_o    (step),
      .residue_o (residue)
   );

   tsu_time_core #(
      .SECNS_MODE (SECNS_MODE),
      .WORD_W     (WORD_W),
      .BIN_W      (BIN_W),
      .STEP_W     (STEP_W),
      .NS_PER_SEC (NS_PER_SEC)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (adv),
      .step_i    (step),
      .load_i    (load),
      .load_hi_i (load_hi),
      .load_lo_i (load_lo),
      .hi_o      (time_hi_o),
      .lo_o      (time_lo_o)
   );

   if (!SECNS_MODE) begin : g_bin_chk
      localparam int HI_USED = BIN_W - WORD_W;
      // R5
      hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd_i && reg_addr_i == REG_THI)
         |=> (reg_rdata_o[WORD_W-1:HI_USED] == '0));
   end

   // R10
   ctrl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && reg_addr_i == REG_CTRL) |=> (reg_rdata_o[WORD_W-2:0] == '0));

   // R2
   halted_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> ($stable(time_hi_o) && $stable(time_lo_o)));
endmodule

// File: tb/tsu_time_counter_bench.sv
`timescale 1ns/1ps
module tsu_time_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata_b, hi_b, lo_b;
   logic [31:0] rdata_s, hi_s, lo_s;

   always #5 clk = ~clk;

   tsu_time_counter #(.SECNS_MODE(1'b0)) u_tsu_time_counter (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_rd_i(rd),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_b),
      .time_hi_o(hi_b), .time_lo_o(lo_b));

   tsu_time_counter #(.SECNS_MODE(1'b1)) u_tsu_time_counter_sn (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_rd_i(rd),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_s),
      .time_hi_o(hi_s), .time_lo_o(lo_s));

   int n_tests = 0;
   int n_fail  = 0;

   // bench model of both formats
   logic [39:0] mb_cnt = '0;
   logic [31:0] ms_sec = '0, ms_ns = '0;
   logic [31:0] m_frac = '0, m_rate = '0, m_pend = '0;
   logic [31:0] mb_snap_hi = '0, mb_snap_lo = '0, ms_snap_hi = '0, ms_snap_lo = '0;
   logic        m_halt = 1'b1;

   task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] f_step(input logic carry, input logic slow);
      if (!carry) return 4'd8;
      return slow ? 4'd7 : 4'd9;
   endfunction

   function automatic logic [63:0] f_sec_adv(input logic [31:0] sec, input logic [31:0] ns,
                                             input logic [3:0] stp);
      logic [32:0] s;
      s = {1'b0, ns} + 33'(stp);
      if (s >= 33'd1000000000) begin
         s = s - 33'd1000000000;
         return {sec + 32'd1, s[31:0]};
      end
      return {sec, s[31:0]};
   endfunction

   task automatic cyc(input bit tk, input bit w, input bit r, input logic [2:0] a,
                      input logic [31:0] d);
      logic [31:0] eb, es;
      logic [39:0] p_cnt;
      logic [31:0] p_sec, p_ns;
      logic [32:0] fsum;
      logic [3:0]  stp;
      logic [63:0] sn;
      tick = tk; wr = w; rd = r; addr = a; wdata = d;
      case (a)
         3'd0: begin eb = m_frac; es = m_frac; end
         3'd1: begin eb = mb_snap_lo; es = ms_snap_lo; end
         3'd2: begin eb = mb_snap_hi; es = ms_snap_hi; end
         3'd3: begin eb = m_rate; es = m_rate; end
         3'd4: begin eb = {m_halt, 31'd0}; es = {m_halt, 31'd0}; end
         default: begin eb = 32'd0; es = 32'd0; end
      endcase
      p_cnt = mb_cnt; p_sec = ms_sec; p_ns = ms_ns;
      @(posedge clk);
      if (w && a == 3'd2) begin
         mb_cnt = {d[7:0], m_pend};
         ms_sec = d; ms_ns = m_pend; m_frac = 32'd0;
      end else if (tk && !m_halt) begin
         fsum = {1'b0, m_frac} + {2'b00, m_rate[30:0]};
         stp = f_step(fsum[32], m_rate[31]);
         m_frac = fsum[31:0];
         mb_cnt = mb_cnt + 40'(stp);
         sn = f_sec_adv(ms_sec, ms_ns, stp);
         ms_sec = sn[63:32]; ms_ns = sn[31:0];
      end
      if (r && a == 3'd0) begin
         mb_snap_hi = {24'd0, p_cnt[39:32]}; mb_snap_lo = p_cnt[31:0];
         ms_snap_hi = p_sec; ms_snap_lo = p_ns;
      end
      if (w) begin
         if (a == 3'd1) m_pend = d;
         if (a == 3'd3) m_rate = d;
         if (a == 3'd4) m_halt = d[31];
      end
      @(negedge clk);
      tick = 1'b0; wr = 1'b0; rd = 1'b0;
      if (r) begin
         chk_eq((a <= 3'd2) ? "R7 read binary" : "R10 read binary", {32'd0, rdata_b}, {32'd0, eb});
         chk_eq((a <= 3'd2) ? "R7 read seconds" : "R10 read seconds", {32'd0, rdata_s}, {32'd0, es});
      end
      chk_eq("R5 live binary time", {hi_b, lo_b}, {24'd0, mb_cnt});
      chk_eq("R6 live seconds time", {hi_s, lo_s}, {ms_sec, ms_ns});
   endtask

   task automatic load_time(input logic [31:0] hi, input logic [31:0] lo);
      cyc(1'b0, 1'b1, 1'b0, 3'd1, lo);
      cyc(1'b0, 1'b1, 1'b0, 3'd2, hi);
   endtask

   initial begin
      #(2_000_000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int unsigned op;
      bit tk;
      void'($urandom(32'd715));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_eq("R1 live time", {hi_b, lo_b}, 64'd0);
      cyc(0, 0, 1, 3'd4, 0); chk_eq("R1 control", {32'd0, rdata_b}, 64'h8000_0000);
      cyc(0, 0, 1, 3'd3, 0); chk_eq("R1 rate", {32'd0, rdata_b}, 64'd0);
      cyc(0, 0, 1, 3'd0, 0); chk_eq("R1 residue", {32'd0, rdata_b}, 64'd0);

      // R2 halted ticks ignored
      repeat (5) cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R2 halted time", {32'd0, lo_b}, 64'd0);

      // R3 nominal 8 ns steps
      cyc(0, 1, 0, 3'd4, 32'h7FFF_FFFF);
      cyc(0, 0, 1, 3'd4, 0); chk_eq("R10 control bit only", {32'd0, rdata_b}, 64'd0);
      repeat (10) cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R3 ten ticks", {32'd0, lo_b}, 64'd80);
      repeat (3) cyc(0, 0, 0, 3'd0, 0);
      chk_eq("R3 idle cycles", {32'd0, lo_b}, 64'd80);

      // R8 write pair, residue write ignored
      cyc(0, 1, 0, 3'd1, 32'd1000);
      chk_eq("R8 low write alone", {32'd0, lo_b}, 64'd80);
      cyc(0, 1, 0, 3'd0, 32'h1234);
      cyc(0, 1, 0, 3'd2, 32'd0);
      chk_eq("R8 pair load", {32'd0, lo_b}, 64'd1000);
      cyc(0, 0, 1, 3'd0, 0); chk_eq("R8 residue cleared", {32'd0, rdata_b}, 64'd0);

      // R7 snapshot
      repeat (3) cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R7 live moved", {32'd0, lo_b}, 64'd1024);
      cyc(0, 0, 1, 3'd1, 0); chk_eq("R7 snapshot low", {32'd0, rdata_b}, 64'd1000);

      // R4 positive and negative trim
      load_time(32'd0, 32'd0);
      cyc(0, 1, 0, 3'd3, 32'h4000_0000);
      repeat (8) cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R4 fast trim", {32'd0, lo_b}, 64'd66);
      repeat (2) cyc(1, 0, 0, 3'd0, 0);
      cyc(0, 0, 1, 3'd0, 0); chk_eq("R4 residue", {32'd0, rdata_b}, 64'h8000_0000);
      load_time(32'd0, 32'd0);
      cyc(0, 1, 0, 3'd3, 32'hC000_0000);
      repeat (8) cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R4 slow trim", {32'd0, lo_b}, 64'd62);

      // R5 wrap and zero upper bits
      cyc(0, 1, 0, 3'd3, 32'd0);
      load_time(32'hABCD_EFFF, 32'hFFFF_FFFC);
      cyc(0, 0, 1, 3'd0, 0);
      cyc(0, 0, 1, 3'd2, 0);
      chk_eq("R5 high upper zero", {32'd0, rdata_b}, 64'hFF);
      chk_eq("R6 high seconds word", {32'd0, rdata_s}, 64'hABCD_EFFF);
      cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R5 wrap", {hi_b, lo_b}, 64'd4);

      // R6 nanosecond rollover
      load_time(32'd5, 32'd999_999_996);
      cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R6 rollover", {hi_s, lo_s}, {32'd6, 32'd4});
      cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R6 after rollover", {hi_s, lo_s}, {32'd6, 32'd12});

      // R9 load beats tick
      cyc(0, 1, 0, 3'd1, 32'h20);
      cyc(1, 1, 0, 3'd2, 32'h10);
      chk_eq("R9 load wins", {hi_b, lo_b}, {32'h10, 32'h20});
      chk_eq("R9 load wins seconds", {hi_s, lo_s}, {32'h10, 32'h20});

      // R2 halt again
      cyc(0, 1, 0, 3'd4, 32'h8000_0000);
      repeat (4) cyc(1, 0, 0, 3'd0, 0);
      chk_eq("R2 halt holds", {32'd0, lo_b}, 64'h20);
      cyc(0, 1, 0, 3'd4, 32'd0);

      // R10 readback and unmapped
      cyc(0, 1, 0, 3'd3, 32'h1357_9BDF);
      cyc(0, 0, 1, 3'd3, 0); chk_eq("R10 rate readback", {32'd0, rdata_b}, 64'h1357_9BDF);
      cyc(0, 0, 1, 3'd5, 0); chk_eq("R10 unmapped", {32'd0, rdata_b}, 64'd0);

      // seeded random traffic
      for (int i = 0; i < 3000; i++) begin
         op = $urandom % 16;
         tk = ($urandom % 4) != 0;
         case (op)
            0: cyc(tk, 1, 0, 3'd1, $urandom % 1000000000);
            1: cyc(tk, 1, 0, 3'd1, $urandom);
            2: cyc(tk, 1, 0, 3'd2, $urandom);
            3: cyc(tk, 1, 0, 3'd3, ($urandom % 2) ? $urandom : ($urandom & 32'h8000_0FFF));
            4, 5, 6: cyc(tk, 0, 1, 3'($urandom % 6), 0);
            7: cyc(tk, 1, 0, 3'd4, (($urandom % 8) == 0) ? 32'h8000_0000 : 32'd0);
            8: cyc(tk, 1, 0, 3'd0, $urandom);
            default: cyc(tk, 0, 0, 3'd0, 0);
         endcase
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule